// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block hands one command to a coprocessor through a small mailbox kept in word-addressed shared memory. The host side gives it a mailbox base address, a command code, a vector of up to `MAX_ARGS` input arguments with a count, and the number of output arguments it wants back. The block reaches shared memory through a plain word request port. That port carries one access at a time, and each access finishes with an acknowledge.

One command runs in this order:
- Check a guard word that sits one word below the mailbox.
- Make sure the mailbox flag is free, then claim it.
- Lay out the command, a fixed timeout word and the argument slots, and mark the mailbox as written.
- Poll the flag at a fixed interval until the coprocessor sets its completion bit, or until the timeout runs out.
- Collect the output arguments and the result word, and release the flag.

The caller gets a one-cycle completion pulse with a two-bit status, the result word and the output arguments.

Top module: `mbox_cmd_seq`

## Requirements
- R1: The first access reads word base-1. If that word is not 0x12345678, the command ends with status 1 and makes no write at all.
- R2: The second access reads the flag word at base. If the flag is nonzero, the command ends with status 2, makes no write, and leaves the flag unchanged.
- R3: The first three writes are, in this order: 1 to base (claim), the command code to base+1, and the parameter `TMO_WORD` to base+3.
- R4: The next `MAX_ARGS` writes go to base+4+i for i = 0 to `MAX_ARGS`-1, in ascending order. Each carries input argument i when i is below the effective input count, and zero otherwise. A requested count above `MAX_ARGS` is clamped to `MAX_ARGS`.
- R5: After the argument slots, the value 3 is written to base.
- R6: After that write, the flag at base is read repeatedly. Successive flag reads are at least `POLL_CYC` cycles apart. Polling stops on the first read that has bit 2 set.
- R7: If no flag read shows bit 2 once `TIMEOUT_CYC` cycles of polling have passed, the command ends with status 3. No further write is made, so the flag stays at 3.
- R8: On completion, the block reads base+4+i for i below the effective output count (clamped to `MAX_ARGS`) into the output slots, and all other slots read zero. It then reads the result from base+2, writes 0 to base, and ends with status 0.
- R9: `done_o` is a one-cycle pulse. `busy_o` rises the cycle after an accepted start and stays high until the pulse. A start while busy is ignored.
- R10: At most one memory access is outstanding. A request and its address, direction and write data stay stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; accepted only when idle |
| base_i | input | AW | Mailbox base word address |
| cmd_i | input | DW | Command code |
| in_cnt_i | input | CW | Number of input arguments |
| out_cnt_i | input | CW | Number of output arguments |
| args_i | input | MAX_ARGS*DW | Input arguments, argument i at bits i*DW |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 guard mismatch, 2 mailbox in use, 3 timeout |
| result_o | output | DW | Result word read from base+2 |
| out_args_o | output | MAX_ARGS*DW | Output arguments, slot i at bits i*DW |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access complete |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |

## Verification
The assertions assume the memory side is well behaved:
- It acknowledges only while a request is pending.
- It gives exactly one acknowledge per access.
- Read data is valid in the acknowledge cycle.

The bench memory model keeps to these rules and inserts a random 0 to 2 cycle wait before each acknowledge. The model also plays the coprocessor. After it sees the value 3 written to the flag, it sets bit 2 following a chosen delay, or never when a timeout is wanted. The assertions also assume that the flag is changed only by the block and by that coprocessor. The bench ensures this by writing to memory only between commands.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  typedef enum logic [1:0] {
    MB_OK      = 2'd0,
    MB_BAD_SIG = 2'd1,
    MB_IN_USE  = 2'd2,
    MB_TIMEOUT = 2'd3
  } mb_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_SIG, S_RD_FLAG, S_WR_CLAIM, S_WR_CMD, S_WR_TMO,
    S_WR_ARG, S_WR_READY, S_POLL_RD, S_POLL_WAIT, S_RD_OUT, S_RD_RES,
    S_WR_CLR, S_FINISH
  } mb_state_e;

endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int POLL_CYC    = 2000,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,      // clear the overall timeout window
  input  logic polling_i,  // inside the polling phase
  input  logic waiting_i,  // inside a gap between flag reads
  output logic due_o,      // gap has lasted POLL_CYC cycles
  output logic expired_o   // polling phase has lasted TIMEOUT_CYC cycles
);
  localparam int GW = $clog2(POLL_CYC + 1);
  localparam int EW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(POLL_CYC - 1);
  localparam logic [EW-1:0] TMO_LIM  = EW'(TIMEOUT_CYC);

  logic [GW-1:0] gap_q, gap_d;
  logic [EW-1:0] el_q, el_d;
  logic          gap_en, el_en;

  assign due_o     = waiting_i && (gap_q == GAP_LAST);
  assign expired_o = (el_q >= TMO_LIM);

  always_comb begin
    gap_en = 1'b1;
    gap_d  = gap_q;
    if (!waiting_i)  gap_d = '0;
    else if (!due_o) gap_d = gap_q + GW'(1);
    else             gap_en = 1'b0;
  end

  always_comb begin
    el_en = 1'b1;
    el_d  = el_q;
    if (arm_i)                        el_d = '0;
    else if (polling_i && !expired_o) el_d = el_q + EW'(1);
    else                              el_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      el_q  <= '0;
    end else begin
      if (gap_en) gap_q <= gap_d;
      if (el_en)  el_q  <= el_d;
    end
  end

  // R6
  gap_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_i && !due_o) |=> (!waiting_i || gap_q == $past(gap_q) + GW'(1)));

endmodule

// File: rtl/mbox_out_bank.sv
module mbox_out_bank #(
  parameter int MAX_ARGS = 16,
  parameter int DW       = 32,
  parameter int CW       = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   wr_en_i,
  input  logic [CW-1:0]          wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [MAX_ARGS*DW-1:0] bank_o
);
  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic          hit;
    assign hit = wr_en_i && (wr_idx_i == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (clr_i) slot_q <= '0;
      else if (hit)   slot_q <= wr_data_i;
    end
    assign bank_o[g*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          DW          = 32,
  parameter int          MAX_ARGS    = 16,
  parameter int          POLL_CYC    = 2000,
  parameter int          TIMEOUT_CYC = 2000000,
  parameter logic [31:0] GUARD_WORD  = 32'h1234_5678,
  parameter logic [31:0] TMO_WORD    = 32'd50000,
  localparam int         CW          = $clog2(MAX_ARGS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [AW-1:0]          base_i,
  input  logic [DW-1:0]          cmd_i,
  input  logic [CW-1:0]          in_cnt_i,
  input  logic [CW-1:0]          out_cnt_i,
  input  logic [MAX_ARGS*DW-1:0] args_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [1:0]             status_o,
  output logic [DW-1:0]          result_o,
  output logic [MAX_ARGS*DW-1:0] out_args_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic [DW-1:0]          mem_rdata_i
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_ARGS);
  localparam logic [CW-1:0] IDX_LAST = CW'(MAX_ARGS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mb_state_e             st_q, st_d;
  logic [AW-1:0]         base_q;
  logic [DW-1:0]         cmd_q;
  logic [MAX_ARGS*DW-1:0] args_q;
  logic [CW-1:0]         in_n_q, out_n_q;
  logic [CW-1:0]         idx_q, idx_d;
  logic [DW-1:0]         res_q, res_d;
  logic [1:0]            stat_q, stat_d;
  logic                  done_q, done_d;
  logic                  sig_ok_q, sig_ok_d;
  logic                  wrote_q, wrote_d;
  logic                  accept, due, expired, cap_out;
  logic [CW-1:0]         in_clamp, out_clamp;

  assign accept    = (st_q == S_IDLE) && start_i;
  assign in_clamp  = (in_cnt_i  > CNT_MAX) ? CNT_MAX : in_cnt_i;
  assign out_clamp = (out_cnt_i > CNT_MAX) ? CNT_MAX : out_cnt_i;
  assign cap_out   = (st_q == S_RD_OUT) && mem_ack_i;

  // command capture, enabled on an accepted start
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q  <= '0;
      cmd_q   <= '0;
      args_q  <= '0;
      in_n_q  <= '0;
      out_n_q <= '0;
    end else if (accept) begin
      base_q  <= base_i;
      cmd_q   <= cmd_i;
      args_q  <= args_i;
      in_n_q  <= in_clamp;
      out_n_q <= out_clamp;
    end
  end

  // memory request decode
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD_SIG:   begin mem_req_o = 1'b1; mem_addr_o = base_q - AW'(1); end
      S_RD_FLAG,
      S_POLL_RD:  mem_req_o = 1'b1;
      S_WR_CLAIM: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = DW'(1); end
      S_WR_CMD:   begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = base_q + AW'(1); mem_wdata_o = cmd_q;
      end
      S_WR_TMO:   begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = base_q + AW'(3); mem_wdata_o = DW'(TMO_WORD);
      end
      S_WR_ARG:   begin
        mem_req_o  = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = base_q + AW'(4) + AW'(idx_q);
        if (idx_q < in_n_q) mem_wdata_o = args_q[int'(idx_q)*DW +: DW];
      end
      S_WR_READY: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = DW'(3); end
      S_RD_OUT:   begin mem_req_o = 1'b1; mem_addr_o = base_q + AW'(4) + AW'(idx_q); end
      S_RD_RES:   begin mem_req_o = 1'b1; mem_addr_o = base_q + AW'(2); end
      S_WR_CLR:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default:    ;
    endcase
  end

  // sequencing
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    res_d    = res_q;
    stat_d   = stat_q;
    done_d   = 1'b0;
    sig_ok_d = sig_ok_q;
    wrote_d  = wrote_q || (mem_req_o && mem_we_o && mem_ack_i);
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d = S_RD_SIG; sig_ok_d = 1'b0; wrote_d = 1'b0; res_d = '0;
      end
      S_RD_SIG: if (mem_ack_i) begin
        if (mem_rdata_i == DW'(GUARD_WORD)) begin
          sig_ok_d = 1'b1; st_d = S_RD_FLAG;
        end else begin
          stat_d = MB_BAD_SIG; st_d = S_FINISH;
        end
      end
      S_RD_FLAG: if (mem_ack_i) begin
        if (mem_rdata_i != '0) begin stat_d = MB_IN_USE; st_d = S_FINISH; end
        else                         st_d = S_WR_CLAIM;
      end
      S_WR_CLAIM: if (mem_ack_i) st_d = S_WR_CMD;
      S_WR_CMD:   if (mem_ack_i) st_d = S_WR_TMO;
      S_WR_TMO:   if (mem_ack_i) begin st_d = S_WR_ARG; idx_d = '0; end
      S_WR_ARG: if (mem_ack_i) begin
        if (idx_q == IDX_LAST) st_d = S_WR_READY;
        else                   idx_d = idx_q + CW'(1);
      end
      S_WR_READY: if (mem_ack_i) st_d = S_POLL_RD;
      S_POLL_RD: if (mem_ack_i) begin
        if (mem_rdata_i[2]) begin
          idx_d = '0;
          st_d  = (out_n_q == '0) ? S_RD_RES : S_RD_OUT;
        end else if (expired) begin
          stat_d = MB_TIMEOUT; st_d = S_FINISH;
        end else begin
          st_d = S_POLL_WAIT;
        end
      end
      S_POLL_WAIT: if (due) st_d = S_POLL_RD;
      S_RD_OUT: if (mem_ack_i) begin
        if (idx_q == out_n_q - CW'(1)) st_d = S_RD_RES;
        else                           idx_d = idx_q + CW'(1);
      end
      S_RD_RES: if (mem_ack_i) begin res_d = mem_rdata_i; st_d = S_WR_CLR; end
      S_WR_CLR: if (mem_ack_i) begin stat_d = MB_OK; st_d = S_FINISH; end
      S_FINISH: begin done_d = 1'b1; st_d = S_IDLE; end
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      res_q    <= '0;
      stat_q   <= MB_OK;
      done_q   <= 1'b0;
      sig_ok_q <= 1'b0;
      wrote_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      res_q    <= res_d;
      stat_q   <= stat_d;
      done_q   <= done_d;
      sig_ok_q <= sig_ok_d;
      wrote_q  <= wrote_d;
    end
  end

  mbox_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arm_i    (st_q == S_WR_READY),
    .polling_i(st_q == S_POLL_RD || st_q == S_POLL_WAIT),
    .waiting_i(st_q == S_POLL_WAIT),
    .due_o    (due),
    .expired_o(expired)
  );

  mbox_out_bank #(.MAX_ARGS(MAX_ARGS), .DW(DW), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (accept),
    .wr_en_i  (cap_out),
    .wr_idx_i (idx_q),
    .wr_data_i(mem_rdata_i),
    .bank_o   (out_args_o)
  );

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign status_o = stat_q;
  assign result_o = res_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R1
  write_after_guard_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_o && mem_we_o) |-> sig_ok_q);
  // R2
  in_use_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && status_o == MB_IN_USE) |-> !wrote_q);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);
  // R9
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o && start_i) |=> busy_o);
  // R7
  timeout_real_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && status_o == MB_TIMEOUT) |-> expired);

endmodule

// File: tb/tb_mbox_cmd_seq.sv
`timescale 1ns/1ps
module tb_mbox_cmd_seq;
  localparam int AW = 16, DW = 32, MAXA = 16, POLL = 8, TMO = 300;
  localparam logic [31:0] TW = 32'd50000;
  localparam int CW = $clog2(MAXA + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [DW-1:0] cmd = '0;
  logic [CW-1:0] icnt = '0, ocnt = '0;
  logic [MAXA*DW-1:0] args = '0;
  logic busy, done, req, we, ack;
  logic [1:0] status;
  logic [DW-1:0] result, wdata, rdata;
  logic [MAXA*DW-1:0] oargs;
  logic [AW-1:0] addr;

  mbox_cmd_seq #(.AW(AW), .DW(DW), .MAX_ARGS(MAXA), .POLL_CYC(POLL),
                 .TIMEOUT_CYC(TMO), .TMO_WORD(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .cmd_i(cmd),
    .in_cnt_i(icnt), .out_cnt_i(ocnt), .args_i(args), .busy_o(busy),
    .done_o(done), .status_o(status), .result_o(result), .out_args_o(oargs),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // shared memory + coprocessor model
  logic [31:0] mem [0:255];
  logic [31:0] lga [0:63];
  logic [31:0] lgd [0:63];
  int nwr, poll_n, gap_bad, cyc, last_poll, lat, cp_cnt;
  bit preset = 0, cp_en = 0, cp_run, ready_seen;
  int cp_delay = 0;
  logic [31:0] pre_sig, pre_flag;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (preset) begin
      for (int k = 0; k < 256; k++) mem[k] <= 32'h0;
      mem[8'(base - 1)] <= pre_sig;
      mem[8'(base)]     <= pre_flag;
      nwr <= 0; poll_n <= 0; gap_bad <= 0; cp_run <= 0; ready_seen <= 0;
      ack <= 1'b0; lat <= 0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (lat == 0) begin
          ack <= 1'b1;
          lat <= $urandom % 3;
          if (we) begin
            mem[addr[7:0]] <= wdata;
            if (nwr < 64) begin lga[nwr] <= 32'(addr); lgd[nwr] <= wdata; end
            nwr <= nwr + 1;
            if (addr == base && wdata == 32'd3) begin
              ready_seen <= 1;
              if (cp_en) begin cp_run <= 1; cp_cnt <= cp_delay; end
            end
          end else begin
            rdata <= mem[addr[7:0]];
            if (addr == base && ready_seen) begin
              if (poll_n > 0 && cyc - last_poll < POLL) gap_bad <= gap_bad + 1;
              last_poll <= cyc;
              poll_n <= poll_n + 1;
            end
          end
        end else lat <= lat - 1;
      end
      if (cp_run) begin
        if (cp_cnt == 0) begin
          cp_run <= 0;
          for (int i = 0; i < MAXA; i++)
            mem[8'(base + 4 + i)] <= mem[8'(base + 4 + i)] + cmd + 32'(i);
          mem[8'(base + 2)] <= cmd ^ 32'hA5A5_0000;
          mem[8'(base)]     <= mem[8'(base)] | 32'd4;
        end else cp_cnt <= cp_cnt - 1;
      end
    end
  end

  function automatic int clampc(input int n);
    return (n > MAXA) ? MAXA : n;
  endfunction
  function automatic logic [31:0] slot_in(input int i);
    return (i < clampc(int'(icnt))) ? args[i*DW +: DW] : 32'h0;
  endfunction
  function automatic logic [31:0] exp_out(input int i);
    return (i < clampc(int'(ocnt))) ? slot_in(i) + cmd + 32'(i) : 32'h0;
  endfunction

  int t_elapsed;
  task automatic run(input logic [31:0] sig, input logic [31:0] flg, input bit copro,
                     input int dly, input bit poke);
    int w;
    @(negedge clk);
    pre_sig = sig; pre_flag = flg; cp_en = copro; cp_delay = dly; preset = 1;
    @(negedge clk);
    preset = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R9 busy after start", 32'(busy), 1);
    w = 1;
    while (!done && w < 5000) begin
      if (poke && w == 10) begin
        start = 1; cmd = cmd + 1;  // ignored: busy
        @(negedge clk); start = 0; cmd = cmd - 1; w++;
      end else begin
        @(negedge clk); w++;
      end
    end
    t_elapsed = w;
    chk(done == 1'b1, "R9 done reached", 32'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done single pulse / idle", {30'b0, done, busy}, 0);
  endtask

  task automatic check_layout(input bit timeout_run);
    chk(lga[0] == 32'(base) && lgd[0] == 1, "R3 claim write", lgd[0], 1);
    chk(lga[1] == 32'(base + 1) && lgd[1] == cmd, "R3 command write", lgd[1], cmd);
    chk(lga[2] == 32'(base + 3) && lgd[2] == TW, "R3 timeout word write", lgd[2], TW);
    for (int i = 0; i < MAXA; i++)
      chk(lga[3+i] == 32'(base + 4 + i) && lgd[3+i] == slot_in(i),
          $sformatf("R4 arg slot %0d", i), lgd[3+i], slot_in(i));
    chk(lga[3+MAXA] == 32'(base) && lgd[3+MAXA] == 3, "R5 written flag", lgd[3+MAXA], 3);
    chk(gap_bad == 0, "R6 poll spacing", 32'(gap_bad), 0);
    if (timeout_run) begin
      chk(nwr == MAXA + 4, "R7 no write after timeout", 32'(nwr), MAXA + 4);
      chk(mem[8'(base)] == 3, "R7 flag left at 3", mem[8'(base)], 3);
    end else begin
      chk(nwr == MAXA + 5 && lga[MAXA+4] == 32'(base) && lgd[MAXA+4] == 0,
          "R8 release write", 32'(nwr), MAXA + 5);
      chk(mem[8'(base)] == 0, "R8 flag cleared", mem[8'(base)], 0);
    end
  endtask

  task automatic check_ok();
    chk(status == 2'd0, "R8 status ok", 32'(status), 0);
    chk(result == (cmd ^ 32'hA5A5_0000), "R8 result", result, cmd ^ 32'hA5A5_0000);
    for (int i = 0; i < MAXA; i++)
      chk(oargs[i*DW +: DW] == exp_out(i), $sformatf("R8 out slot %0d", i),
          oargs[i*DW +: DW], exp_out(i));
    check_layout(0);
  endtask

  task automatic rand_cmd(input int ni, input int no);
    base = AW'(16 + ($urandom % 200));
    cmd  = $urandom;
    icnt = CW'(ni); ocnt = CW'(no);
    for (int i = 0; i < MAXA; i++) args[i*DW +: DW] = $urandom;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && req == 0 && status == 0, "R9 reset state",
        {28'b0, busy, done, req, 1'b0}, 0);

    // R1: guard mismatch
    rand_cmd(3, 2);
    run(32'hDEAD_BEEF, 0, 1, 5, 0);
    chk(status == 2'd1, "R1 bad guard status", 32'(status), 1);
    chk(nwr == 0, "R1 no writes", 32'(nwr), 0);

    // R2: mailbox in use
    rand_cmd(3, 2);
    run(32'h1234_5678, 32'h5, 1, 5, 0);
    chk(status == 2'd2, "R2 in-use status", 32'(status), 2);
    chk(nwr == 0 && mem[8'(base)] == 5, "R2 flag untouched", mem[8'(base)], 5);

    // full argument sets, long coprocessor delay (several polls)
    rand_cmd(16, 16);
    run(32'h1234_5678, 0, 1, 60, 0);
    check_ok();
    chk(poll_n >= 3, "R6 several polls", 32'(poll_n), 3);

    // no arguments either way
    rand_cmd(0, 0);
    run(32'h1234_5678, 0, 1, 0, 0);
    check_ok();

    // counts above maximum clamp (R4, R8)
    rand_cmd(25, 31);
    run(32'h1234_5678, 0, 1, 12, 0);
    check_ok();

    // R7: coprocessor never answers
    rand_cmd(5, 4);
    run(32'h1234_5678, 0, 0, 0, 0);
    chk(status == 2'd3, "R7 timeout status", 32'(status), 3);
    chk(t_elapsed >= TMO, "R7 waited the full window", 32'(t_elapsed), TMO);
    check_layout(1);

    // R9: start while busy is ignored
    rand_cmd(4, 3);
    run(32'h1234_5678, 0, 1, 40, 1);
    check_ok();

    for (int t = 0; t < 15; t++) begin
      rand_cmd($urandom % 20, $urandom % 20);
      run(32'h1234_5678, 0, 1, $urandom % 50, 0);
      check_ok();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule